// File: doc/BRIEF.md
# Windowed memory address decoder

This block decides whether an access on a 20-bit host address bus falls inside a movable memory window, and turns that host address into an address for the local memory behind the window. Software programs three 8-bit registers over a small register port. A match register sets where the window sits in host space. A bank register sets which local memory region the window shows. A size register sets how large the window is.

The size register holds one mask bit for each of host address bits 19 down to 12. When a mask bit is set, that address bit takes no part in the match compare, and in the local address that bit comes from the host address instead of the bank register. The mask is meant to fill from the low end upward, so the window grows in powers of two from 8K to 256K. Some size bits are hard-wired. Bit 0 is always set, so the smallest window is 8K. Bits 7 and 6 are always clear, so address bits 19 and 18 are always compared.

Host address bits 11 to 0 always pass through to the local address unchanged. Register writes are registered. The hit flag and the local address are combinational from the stored registers and the host address.

Top module: `win_decoder`

## Requirements
- R1: After reset the match register (register address 0) reads 0x00, the bank register (register address 1) reads 0x00 and the size register (register address 2) reads 0x03, which selects a 16K window.
- R2: A write with regWrEn high stores regWrData into the register selected by regAddr on the next rising clock edge. The read value does not change before that edge. The match and bank registers read back all 8 bits exactly as written.
- R3: Size register bits 7 and 6 always read 0, whatever value is written.
- R4: Size register bit 0 always reads 1, whatever value is written.
- R5: Size register bits 5 to 1 store and read back the written value. With no write to the size register, the effective mask stays unchanged.
- R6: windowHit is high exactly when every host address bit 19..12 whose mask bit is clear equals the matching match-register bit (match bit 7 pairs with address bit 19). Address bits 19 and 18 are therefore always compared.
- R7: For each bit 19..12 of localAddr, the bit comes from the host address when its mask bit is set and from the bank register when its mask bit is clear.
- R8: localAddr bits 11..0 always equal hostAddr bits 11..0.
- R9: With the size register written to 0x01, 0x03, 0x07, 0x0F, 0x1F or 0x3F, the hit range is an aligned block of 8K, 16K, 32K, 64K, 128K or 256K respectively. The addresses one below the block and one past its end miss.
- R10: Register address 3 reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 match, 1 bank, 2 size, 3 unused |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data of the register selected by regAddr |
| hostAddr | input | 20 | Host bus address |
| windowHit | output | 1 | Host address lies inside the window |
| localAddr | output | 20 | Translated local memory address |

## Verification
The bench builds the block with its default parameters: a 20-bit host address, an 8-bit window slice and the fixed mask bits at bit 0 (set) and bits 7..6 (clear). These defaults bring every legal window size within reach, from 8K through 256K. For each size the bench probes the block's first and last address and the addresses just outside it. The fixed bits are exercised by writing all-ones and all-zeros to the size register. Non-thermometer mask values are not used for any window-size claim.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

  typedef enum logic [1:0] {
    SEL_MATCH = 2'd0,
    SEL_BANK  = 2'd1,
    SEL_SIZE  = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrMatch;
    logic    wrBank;
    logic    wrSize;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/win_ctrl.sv
module win_ctrl
  import win_dec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [1:0]   regAddr,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes         = '0;
    strobes.rdSel   = regSel_e'(regAddr);
    if (regWrEn) begin
      case (regSel_e'(regAddr))
        SEL_MATCH: strobes.wrMatch = 1'b1;
        SEL_BANK:  strobes.wrBank  = 1'b1;
        SEL_SIZE:  strobes.wrSize  = 1'b1;
        default:   ;
      endcase
    end
  end

  // R10: at most one register is written in any cycle
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrMatch, strobes.wrBank, strobes.wrSize}));

  // R2: no strobe without a write request
  a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(strobes.wrMatch || strobes.wrBank || strobes.wrSize));

endmodule

// File: rtl/win_dp.sv
module win_dp
  import win_dec_pkg::*;
#(
  parameter int              SLICE_W  = 8,
  parameter int              OFFSET_W = 12,
  parameter logic [SLICE_W-1:0] RO_ONE   = 8'h01,
  parameter logic [SLICE_W-1:0] RO_ZERO  = 8'hC0,
  parameter logic [SLICE_W-1:0] SIZE_RST = 8'h03
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 strobes,
  input  logic [SLICE_W-1:0]           wrData,
  input  logic [SLICE_W+OFFSET_W-1:0]  hostAddr,
  output logic [SLICE_W-1:0]           rdData,
  output logic                         windowHit,
  output logic [SLICE_W+OFFSET_W-1:0]  localAddr
);

  localparam int ADDR_W = SLICE_W + OFFSET_W;

  logic [SLICE_W-1:0] matchQ;
  logic [SLICE_W-1:0] bankQ;
  logic [SLICE_W-1:0] effMask;
  logic [SLICE_W-1:0] hostSlice;
  logic [SLICE_W-1:0] localSlice;
  logic [SLICE_W-1:0] diffBits;

  assign hostSlice = hostAddr[ADDR_W-1:OFFSET_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchQ <= '0;
      bankQ  <= '0;
    end else begin
      if (strobes.wrMatch) matchQ <= wrData;
      if (strobes.wrBank)  bankQ  <= wrData;
    end
  end

  // Per-bit size mask: hard-wired bits are constants, the rest are flops
  for (genvar i = 0; i < SLICE_W; i++) begin : g_mask
    if (RO_ONE[i]) begin : g_one
      assign effMask[i] = 1'b1;
    end else if (RO_ZERO[i]) begin : g_zero
      assign effMask[i] = 1'b0;
    end else begin : g_rw
      logic bitQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              bitQ <= SIZE_RST[i];
        else if (strobes.wrSize) bitQ <= wrData[i];
      end
      assign effMask[i] = bitQ;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_MATCH: rdData = matchQ;
      SEL_BANK:  rdData = bankQ;
      SEL_SIZE:  rdData = effMask;
      default:   rdData = '0;
    endcase
  end

  assign diffBits   = (hostSlice ^ matchQ) & ~effMask;
  assign windowHit  = (diffBits == '0);
  assign localSlice = (bankQ & ~effMask) | (hostSlice & effMask);
  assign localAddr  = {localSlice, hostAddr[OFFSET_W-1:0]};

  // R2: a match write shows up one edge later
  a_r2_match_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrMatch |=> (matchQ == $past(wrData)));

  // R2: a bank write shows up one edge later
  a_r2_bank_write: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrBank |=> (bankQ == $past(wrData)));

  // R5: the mask holds while no size write occurs
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrSize |=> $stable(effMask));

  // R6: a hit implies the always-compared bits agree
  a_r6_top_compared: assert property (@(posedge clk) disable iff (!rstN)
    windowHit |-> ((hostSlice & RO_ZERO) == (matchQ & RO_ZERO)));

  // R7: always-masked bits come from host, always-compared bits from bank
  a_r7_fixed_sources: assert property (@(posedge clk) disable iff (!rstN)
    ((localAddr[ADDR_W-1:OFFSET_W] & RO_ONE) == (hostSlice & RO_ONE)) &&
    ((localAddr[ADDR_W-1:OFFSET_W] & RO_ZERO) == (bankQ & RO_ZERO)));

  // R8: the low offset passes through
  a_r8_offset_pass: assert property (@(posedge clk) disable iff (!rstN)
    localAddr[OFFSET_W-1:0] == hostAddr[OFFSET_W-1:0]);

endmodule

// File: rtl/win_decoder.sv
module win_decoder
  import win_dec_pkg::*;
#(
  parameter int                 ADDR_W   = 20,
  parameter int                 SLICE_W  = 8,
  parameter logic [SLICE_W-1:0] RO_ONE   = 8'h01,
  parameter logic [SLICE_W-1:0] RO_ZERO  = 8'hC0,
  parameter logic [SLICE_W-1:0] SIZE_RST = 8'h03
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [SLICE_W-1:0] regWrData,
  output logic [SLICE_W-1:0] regRdData,
  input  logic [ADDR_W-1:0]  hostAddr,
  output logic               windowHit,
  output logic [ADDR_W-1:0]  localAddr
);

  localparam int OFFSET_W = ADDR_W - SLICE_W;

  ctrlStrobes_t strobes;

  win_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  win_dp #(
    .SLICE_W  (SLICE_W),
    .OFFSET_W (OFFSET_W),
    .RO_ONE   (RO_ONE),
    .RO_ZERO  (RO_ZERO),
    .SIZE_RST (SIZE_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .hostAddr  (hostAddr),
    .rdData    (regRdData),
    .windowHit (windowHit),
    .localAddr (localAddr)
  );

endmodule

// File: tb/tb_win_decoder.sv
module tb_win_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [7:0]  regWrData = 8'h00;
  logic [7:0]  regRdData;
  logic [19:0] hostAddr = 20'h0;
  logic        windowHit;
  logic [19:0] localAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  win_decoder dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .hostAddr  (hostAddr),
    .windowHit (windowHit),
    .localAddr (localAddr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, {24'h0, regRdData}, {24'h0, exp});
  endtask

  task automatic probe(input string tag, input logic [19:0] a,
                       input logic expHit, input logic [19:0] expLocal);
    hostAddr = a;
    #1;
    check({tag, " hit"}, {31'h0, windowHit}, {31'h0, expHit});
    check({tag, " local"}, {12'h0, localAddr}, {12'h0, expLocal});
  endtask

  task automatic testReset();
    rdCheck("R1 match reset", 2'd0, 8'h00);
    rdCheck("R1 bank reset", 2'd1, 8'h00);
    rdCheck("R1 size reset", 2'd2, 8'h03);
  endtask

  task automatic testWriteTiming();
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h5A;
    #1;
    check("R2 match before edge", {24'h0, regRdData}, 32'h00);
    @(negedge clk);
    regWrEn = 1'b0;
    rdCheck("R2 match after edge", 2'd0, 8'h5A);
    wrReg(2'd1, 8'hC3);
    rdCheck("R2 bank readback", 2'd1, 8'hC3);
    rdCheck("R2 match kept", 2'd0, 8'h5A);
  endtask

  task automatic testSizeBits();
    wrReg(2'd2, 8'hFF);
    rdCheck("R3 R5 size all ones", 2'd2, 8'h3F);
    wrReg(2'd2, 8'h00);
    rdCheck("R4 size all zeros", 2'd2, 8'h01);
    wrReg(2'd2, 8'h2A);
    rdCheck("R5 size pattern", 2'd2, 8'h2B);
    wrReg(2'd2, 8'hD4);
    rdCheck("R5 size pattern2", 2'd2, 8'h15);
  endtask

  task automatic testUnused();
    wrReg(2'd0, 8'h11);
    wrReg(2'd1, 8'h22);
    wrReg(2'd2, 8'h07);
    wrReg(2'd3, 8'hFF);
    rdCheck("R10 unused reads zero", 2'd3, 8'h00);
    rdCheck("R10 match untouched", 2'd0, 8'h11);
    rdCheck("R10 bank untouched", 2'd1, 8'h22);
    rdCheck("R10 size untouched", 2'd2, 8'h07);
  endtask

  task automatic testDefaultTranslate();
    // 16K window, match 0xA4, bank 0x5B
    wrReg(2'd0, 8'hA4);
    wrReg(2'd1, 8'h5B);
    wrReg(2'd2, 8'h03);
    probe("R7 16K inside", 20'hA7ABC, 1'b1, 20'h5BABC);
    probe("R8 offset", 20'hA4123, 1'b1, 20'h58123);
    probe("R6 bit19 differs", 20'h27ABC, 1'b0, 20'h5BABC);
    wrReg(2'd2, 8'h3F);
    probe("R6 bit18 differs", 20'hC0000, 1'b0, 20'h40000);
    probe("R6 top bits match", 20'h80000, 1'b1, 20'h40000);
  endtask

  task automatic testLegalSizes();
    logic [7:0]  mask;
    logic [19:0] span;
    logic [19:0] base;
    logic [19:0] bankPart;
    wrReg(2'd0, 8'hA4);
    wrReg(2'd1, 8'h5B);
    for (int k = 1; k <= 6; k++) begin
      mask = 8'((1 << k) - 1);
      span = 20'(32'h1000 << k);
      base = {8'hA4 & ~mask, 12'h000};
      bankPart = {8'h5B & ~mask, 12'h000};
      wrReg(2'd2, mask);
      rdCheck($sformatf("R9 size 0x%0h readback", mask), 2'd2, mask);
      probe($sformatf("R9 size %0dK first", span >> 10), base, 1'b1, bankPart);
      probe($sformatf("R9 size %0dK last", span >> 10), base + span - 20'd1, 1'b1,
            bankPart | (span - 20'd1));
      probe($sformatf("R9 size %0dK past end", span >> 10), base + span, 1'b0,
            bankPart | 20'h0);
      hostAddr = base - 20'd1;
      #1;
      check($sformatf("R9 size %0dK below", span >> 10), {31'h0, windowHit}, 32'h0);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteTiming();
    testSizeBits();
    testUnused();
    testDefaultTranslate();
    testLegalSizes();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule